// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate

This block is the enhanced-mode part of a host parallel port controller. A host bus reaches it through a small byte-addressed window, with a second window for the extended-capability registers. Two offsets start peripheral transfers: offset 3 runs address cycles and offset 4 runs data cycles. Offset 4 also accepts 16-bit and 32-bit accesses, which are split into byte cycles with the least significant byte first. The block also holds the port's data and control registers and the status view.

A transfer starts only when the stored control register holds one exact pattern. Writes need one pattern and reads need another. If the pattern does not match, a write is dropped and a read returns all ones at the access width. Each byte cycle drives the direction line and then one of two strobes. It waits for the peripheral's wait line to rise and for it to fall again. If the wait line does not move within a build-time number of cycles, the access aborts: its remaining bytes are skipped and a sticky timeout flag is set. The flag shows in bit 0 of the status read and is cleared by writing 1 to that bit. The host ready line stays low while byte cycles are running.

Top module: `eppgate`

## Requirements
- R1: After reset, hostReady is 1. The control register reads 0xCC and the data register reads 0xFF. A status read returns periphStatus with bit 0 equal to 0.
- R2: A control write stores the value with bits 7 and 6 forced to 1. A write that equals the stored control value gives no ctrlLoad pulse. A data write equal to the stored data gives no dataLoad pulse. Any write that changes either register gives a one-cycle pulse on the matching load output.
- R3: A write at offset 3 or 4 runs byte cycles only when control bits {5,3,2,1,0} equal 0,0,1,0,0, that is (control & 0x2F) == 0x04. Otherwise no strobe is driven.
- R4: A read at offset 3 or 4 runs byte cycles only when (control & 0x2F) == 0x24. Otherwise no strobe is driven and the read returns 0xFF, 0xFFFF or 0xFFFFFFFF for a size code of 0, 1 or 2, zero-extended.
- R5: In every byte cycle, eppWrite is 1 for writes and 0 for reads. Exactly one strobe is raised: eppAddrStb for offset 3 and eppDataStb for offset 4. The strobe is held until eppWait is seen high, then released. eppWrite and eppBusOut stay stable while the strobe is high.
- R6: At offset 4, size code 0, 1 or 2 moves 1, 2 or 4 bytes, least significant byte first. Offset 3 always moves a single byte (the low byte).
- R7: A read assembles captured bytes little-endian into hostRdata. Lanes above the access width read 0.
- R8: If eppWait does not respond within TIMEOUT_CYCLES cycles, the access aborts. The timeout flag is set and no further byte of that access is transferred.
- R9: A status read returns periphStatus with bit 0 replaced by the timeout flag. A status write with bit 0 set clears the flag. A status write with bit 0 clear leaves it unchanged.
- R10: With hostExt = 1, reads at every offset return 0xFF and writes change no register.
- R11: hostReady is low from the accepting edge of a running transfer until its last byte cycle ends or aborts. Register accesses and dropped transfers keep hostReady high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Access request, taken on an edge where hostReady is 1 |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostExt | input | 1 | Selects the extended-capability window |
| hostAddr | input | 3 | Register offset |
| hostSize | input | 2 | Access size: 0 = byte, 1 = 16-bit, 2 = 32-bit |
| hostWdata | input | DATA_W | Write data |
| hostRdata | output | DATA_W | Read data of the last completed access |
| hostReady | output | 1 | Idle; request accepted and read data valid |
| periphStatus | input | 8 | Peripheral status lines |
| eppBusIn | input | 8 | Byte driven by the peripheral during reads |
| eppBusOut | output | 8 | Byte driven toward the peripheral |
| eppWait | input | 1 | Peripheral handshake response |
| eppWrite | output | 1 | Cycle direction, 1 = write |
| eppAddrStb | output | 1 | Address-cycle strobe |
| eppDataStb | output | 1 | Data-cycle strobe |
| portData | output | 8 | Stored data register |
| portCtrl | output | 8 | Stored control register |
| dataLoad | output | 1 | One-cycle pulse when the data register changes |
| ctrlLoad | output | 1 | One-cycle pulse when the control register changes |

## Verification
The bench builds the block with DATA_W = 32 and TIMEOUT_CYCLES = 6. With such a short limit, an unresponsive peripheral aborts a transfer within a few cycles, and responses delayed by 0 to 2 cycles still complete. The bench sweeps all 32 combinations of the five gating control bits, once for writes and once for reads. It then runs every access size at both cycle offsets under several response delays, and covers the timeout path with a peripheral that never answers.

// File: rtl/eppgate_pkg.sv
package eppgate_pkg;
  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_STAT  = 3'd1;
  localparam logic [2:0] OFS_CTRL  = 3'd2;
  localparam logic [2:0] OFS_EADDR = 3'd3;
  localparam logic [2:0] OFS_EDATA = 3'd4;

  localparam logic [7:0] GATE_MASK  = 8'h2F;
  localparam logic [7:0] GATE_WRITE = 8'h04;
  localparam logic [7:0] GATE_READ  = 8'h24;
  localparam logic [7:0] CTRL_FIXED = 8'hC0;
  localparam logic [7:0] CTRL_RESET = 8'hCC;
  localparam logic [7:0] DATA_RESET = 8'hFF;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_STROBE, SQ_RELEASE} seqState_t;

  // strobes from the sequencer to the register datapath
  typedef struct packed {
    logic captureByte;
    logic setTimeout;
  } seqStrobes_t;
endpackage

// File: rtl/eppgate_seq.sv
module eppgate_seq
  import eppgate_pkg::*;
#(
  parameter int LANE_W = 2,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runGo,
  input  logic              runIsAddr,
  input  logic              runIsWrite,
  input  logic [LANE_W-1:0] runLast,
  input  logic              eppWait,
  output seqStrobes_t       strobes,
  output logic [LANE_W-1:0] byteIdx,
  output logic              hostReady,
  output logic              eppAddrStb,
  output logic              eppDataStb,
  output logic              eppWrite
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  seqState_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [LANE_W-1:0] lastIdx;
  logic              isAddr;
  logic              isWrite;
  logic              expired;

  assign expired    = (cnt == CNT_LAST);
  assign hostReady  = (state == SQ_IDLE);
  assign eppWrite   = (state != SQ_IDLE) && isWrite;
  assign eppAddrStb = (state == SQ_STROBE) && isAddr;
  assign eppDataStb = (state == SQ_STROBE) && !isAddr;

  always_comb begin
    strobes.captureByte = (state == SQ_STROBE) && eppWait && !isWrite;
    strobes.setTimeout  = expired &&
                          (((state == SQ_STROBE) && !eppWait) ||
                           ((state == SQ_RELEASE) && eppWait));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= SQ_IDLE;
      cnt     <= '0;
      byteIdx <= '0;
      lastIdx <= '0;
      isAddr  <= 1'b0;
      isWrite <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: if (runGo) begin
          state   <= SQ_SETUP;
          byteIdx <= '0;
          lastIdx <= runLast;
          isAddr  <= runIsAddr;
          isWrite <= runIsWrite;
        end
        SQ_SETUP: begin
          state <= SQ_STROBE;
          cnt   <= '0;
        end
        SQ_STROBE: begin
          if (eppWait) begin
            state <= SQ_RELEASE;
            cnt   <= '0;
          end else if (expired) begin
            state <= SQ_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: begin
          if (!eppWait) begin
            if (byteIdx == lastIdx) begin
              state <= SQ_IDLE;
            end else begin
              byteIdx <= byteIdx + LANE_W'(1);
              state   <= SQ_SETUP;
            end
          end else if (expired) begin
            state <= SQ_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      endcase
    end
  end

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == SQ_STROBE) |-> (cnt < CNT_W'(TIMEOUT_CYCLES)));

  assert_launch_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    runGo |-> hostReady);
endmodule

// File: rtl/eppgate_regs.sv
module eppgate_regs
  import eppgate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES = 4,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accept,
  input  logic              hostWrite,
  input  logic              hostExt,
  input  logic [2:0]        hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [7:0]        periphStatus,
  input  logic [7:0]        eppBusIn,
  input  seqStrobes_t       strobes,
  input  logic [LANE_W-1:0] byteIdx,
  output logic              runGo,
  output logic              runIsAddr,
  output logic [LANE_W-1:0] runLast,
  output logic [DATA_W-1:0] hostRdata,
  output logic [7:0]        eppBusOut,
  output logic [7:0]        portData,
  output logic [7:0]        portCtrl,
  output logic              dataLoad,
  output logic              ctrlLoad
);
  logic [7:0]        ctrlQ, dataQ, ctrlNext, statusView;
  logic              timeoutQ, isCycleOfs, gateWr, gateRd;
  logic [DATA_W-1:0] wordQ, rdataQ, widthMask;
  logic [LANE_W-1:0] sizeLast;
  logic [7:0]        lanesW [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanesW[g] = wordQ[g*8 +: 8];
  end

  assign eppBusOut  = lanesW[byteIdx];
  assign portData   = dataQ;
  assign portCtrl   = ctrlQ;
  assign hostRdata  = rdataQ;
  assign ctrlNext   = CTRL_FIXED | hostWdata[7:0];
  assign statusView = (periphStatus & 8'hFE) | {7'd0, timeoutQ};
  assign isCycleOfs = !hostExt && ((hostAddr == OFS_EADDR) || (hostAddr == OFS_EDATA));
  assign gateWr     = (ctrlQ & GATE_MASK) == GATE_WRITE;
  assign gateRd     = (ctrlQ & GATE_MASK) == GATE_READ;
  assign runGo      = accept && isCycleOfs && (hostWrite ? gateWr : gateRd);
  assign runIsAddr  = (hostAddr == OFS_EADDR);

  always_comb begin
    case (hostSize)
      2'd0:    sizeLast = '0;
      2'd1:    sizeLast = LANE_W'(1);
      default: sizeLast = LANE_W'(LANES - 1);
    endcase
    runLast = (hostAddr == OFS_EDATA) ? sizeLast : '0;
    widthMask = '0;
    for (int i = 0; i < LANES; i++) begin
      widthMask[i*8 +: 8] = (i <= int'(runLast)) ? 8'hFF : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= CTRL_RESET;
      dataQ    <= DATA_RESET;
      timeoutQ <= 1'b0;
      wordQ    <= '0;
      rdataQ   <= '0;
      dataLoad <= 1'b0;
      ctrlLoad <= 1'b0;
    end else begin
      dataLoad <= 1'b0;
      ctrlLoad <= 1'b0;
      if (accept) begin
        if (hostExt) begin
          if (!hostWrite) rdataQ <= DATA_W'(8'hFF);
        end else if (hostWrite) begin
          case (hostAddr)
            OFS_DATA: if (hostWdata[7:0] != dataQ) begin
              dataQ    <= hostWdata[7:0];
              dataLoad <= 1'b1;
            end
            OFS_STAT: if (hostWdata[0]) timeoutQ <= 1'b0;
            OFS_CTRL: if (ctrlNext != ctrlQ) begin
              ctrlQ    <= ctrlNext;
              ctrlLoad <= 1'b1;
            end
            OFS_EADDR, OFS_EDATA: wordQ <= hostWdata;
            default: ;
          endcase
        end else begin
          case (hostAddr)
            OFS_DATA:             rdataQ <= DATA_W'(dataQ);
            OFS_STAT:             rdataQ <= DATA_W'(statusView);
            OFS_CTRL:             rdataQ <= DATA_W'(ctrlQ);
            OFS_EADDR, OFS_EDATA: rdataQ <= widthMask;
            default:              rdataQ <= DATA_W'(8'hFF);
          endcase
        end
      end
      if (strobes.captureByte) rdataQ[{byteIdx, 3'b000} +: 8] <= eppBusIn;
      if (strobes.setTimeout) timeoutQ <= 1'b1;
    end
  end

  assert_data_change_R2: assert property (@(posedge clk) disable iff (!rstN)
    dataLoad |-> (portData != $past(portData)));

  assert_ctrl_change_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrlLoad |-> (portCtrl != $past(portCtrl)));

  assert_timeout_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutQ) |-> $past(strobes.setTimeout));

  assert_no_capture_on_accept_R11: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> !strobes.captureByte);
endmodule

// File: rtl/eppgate.sv
module eppgate
  import eppgate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic              hostExt,
  input  logic [2:0]        hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostReady,
  input  logic [7:0]        periphStatus,
  input  logic [7:0]        eppBusIn,
  output logic [7:0]        eppBusOut,
  input  logic              eppWait,
  output logic              eppWrite,
  output logic              eppAddrStb,
  output logic              eppDataStb,
  output logic [7:0]        portData,
  output logic [7:0]        portCtrl,
  output logic              dataLoad,
  output logic              ctrlLoad
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  seqStrobes_t       strobes;
  logic [LANE_W-1:0] byteIdx, runLast;
  logic              accept, runGo, runIsAddr, anyStb;

  assign accept = hostReq && hostReady;
  assign anyStb = eppAddrStb || eppDataStb;

  eppgate_regs #(.DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W)) uRegs (
    .clk(clk), .rstN(rstN), .accept(accept), .hostWrite(hostWrite),
    .hostExt(hostExt), .hostAddr(hostAddr), .hostSize(hostSize),
    .hostWdata(hostWdata), .periphStatus(periphStatus), .eppBusIn(eppBusIn),
    .strobes(strobes), .byteIdx(byteIdx), .runGo(runGo), .runIsAddr(runIsAddr),
    .runLast(runLast), .hostRdata(hostRdata), .eppBusOut(eppBusOut),
    .portData(portData), .portCtrl(portCtrl), .dataLoad(dataLoad),
    .ctrlLoad(ctrlLoad)
  );

  eppgate_seq #(.LANE_W(LANE_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) uSeq (
    .clk(clk), .rstN(rstN), .runGo(runGo), .runIsAddr(runIsAddr),
    .runIsWrite(hostWrite), .runLast(runLast), .eppWait(eppWait),
    .strobes(strobes), .byteIdx(byteIdx), .hostReady(hostReady),
    .eppAddrStb(eppAddrStb), .eppDataStb(eppDataStb), .eppWrite(eppWrite)
  );

  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({eppAddrStb, eppDataStb}));

  assert_bus_steady_R5: assert property (@(posedge clk) disable iff (!rstN)
    (anyStb && $past(anyStb)) |-> $stable({eppWrite, eppBusOut}));

  assert_busy_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    anyStb |-> !hostReady);
endmodule

// File: tb/eppgate_test.sv
module eppgate_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0, hostWrite = 1'b0, hostExt = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [1:0]  hostSize = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostReady;
  logic [7:0]  periphStatus = 8'h80;
  logic [7:0]  eppBusIn, eppBusOut, portData, portCtrl;
  logic        eppWait = 1'b0;
  logic        eppWrite, eppAddrStb, eppDataStb, dataLoad, ctrlLoad;

  always #5 clk = ~clk;

  eppgate #(.DATA_W(32), .TIMEOUT_CYCLES(6)) uut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostExt(hostExt), .hostAddr(hostAddr), .hostSize(hostSize),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostReady(hostReady),
    .periphStatus(periphStatus), .eppBusIn(eppBusIn), .eppBusOut(eppBusOut),
    .eppWait(eppWait), .eppWrite(eppWrite), .eppAddrStb(eppAddrStb),
    .eppDataStb(eppDataStb), .portData(portData), .portCtrl(portCtrl),
    .dataLoad(dataLoad), .ctrlLoad(ctrlLoad)
  );

  int errors = 0;
  int checks = 0;

  // peripheral model
  logic deaf = 1'b0;
  int   respDelay = 0;
  int   stbHigh = 0;
  wire  anyStb = eppAddrStb | eppDataStb;
  always @(posedge clk) begin
    if (anyStb) begin
      if (!deaf && stbHigh >= respDelay) eppWait <= 1'b1;
      stbHigh <= stbHigh + 1;
    end else begin
      eppWait <= 1'b0;
      stbHigh <= 0;
    end
  end

  // strobe monitor
  int         stbCount = 0;
  logic       prevStb = 1'b0;
  logic [7:0] byteLog [64];
  logic       kindLog [64];
  logic       wrLog [64];
  always @(posedge clk) begin
    prevStb <= anyStb;
    if (anyStb && !prevStb) begin
      byteLog[stbCount % 64] <= eppBusOut;
      kindLog[stbCount % 64] <= eppAddrStb;
      wrLog[stbCount % 64]   <= eppWrite;
      stbCount <= stbCount + 1;
    end
  end
  assign eppBusIn = 8'h40 + 8'(stbCount);

  logic sawDataLoad, sawCtrlLoad;
  int   busyCycles;

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic ext, input logic [2:0] addr, input logic wr,
                        input logic [1:0] size, input logic [31:0] wd,
                        output logic [31:0] rd);
    @(negedge clk);
    hostReq = 1'b1; hostExt = ext; hostAddr = addr; hostWrite = wr;
    hostSize = size; hostWdata = wd;
    @(posedge clk);
    #1 hostReq = 1'b0;
    busyCycles = 0;
    @(negedge clk);
    sawDataLoad = dataLoad;
    sawCtrlLoad = ctrlLoad;
    while (!hostReady && busyCycles < 500) begin
      busyCycles++;
      @(negedge clk);
    end
    rd = hostRdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    chkEq("R1 ready", 32'(hostReady), 32'd1);
    access(0, 3'd2, 0, 2'd0, 0, rd); chkEq("R1 ctrl", rd, 32'hCC);
    access(0, 3'd0, 0, 2'd0, 0, rd); chkEq("R1 data", rd, 32'hFF);
    access(0, 3'd1, 0, 2'd0, 0, rd); chkEq("R1 status", rd, 32'h80);
    chkEq("R11 register access keeps ready", 32'(busyCycles), 32'd0);

    // R3 / R4 sweep of all gating control combinations
    for (int c = 0; c < 32; c++) begin
      logic [7:0] v;
      logic [7:0] pat;
      v = {2'b00, 1'(c >> 4), 1'b0, 4'(c)};
      pat = v & 8'h2F;
      access(0, 3'd2, 1, 2'd0, 32'(v), rd);
      base = stbCount;
      access(0, 3'd4, 1, 2'd0, 32'(c) ^ 32'h5A, rd);
      chkEq("R3 write gate strobes", 32'(stbCount - base), (pat == 8'h04) ? 32'd1 : 32'd0);
      if (pat == 8'h04) chkEq("R3 gated byte", 32'(byteLog[base % 64]), 32'(c) ^ 32'h5A);
      base = stbCount;
      access(0, 3'd4, 0, 2'd0, 0, rd);
      chkEq("R4 read gate strobes", 32'(stbCount - base), (pat == 8'h24) ? 32'd1 : 32'd0);
      chkEq("R4 read gate data", rd, (pat == 8'h24) ? 32'(8'(8'h41 + 8'(base))) : 32'hFF);
    end

    // R5 / R6 / R11 write handshakes under several delays
    access(0, 3'd2, 1, 2'd0, 32'h04, rd);
    for (int d = 0; d < 3; d++) begin
      respDelay = d;
      base = stbCount;
      access(0, 3'd4, 1, 2'd1, 32'h1234BEEF, rd);
      chkEq("R6 half count", 32'(stbCount - base), 32'd2);
      chkEq("R6 half lsb first", {16'd0, byteLog[(base + 1) % 64], byteLog[base % 64]}, 32'hBEEF);
      chkEq("R5 data strobe kind", 32'(kindLog[base % 64]), 32'd0);
      chkEq("R5 write direction", 32'(wrLog[base % 64]), 32'd1);
      chkEq("R11 ready low during run", 32'(busyCycles > 0), 32'd1);
      base = stbCount;
      access(0, 3'd4, 1, 2'd2, 32'h12345678 + 32'(d), rd);
      chkEq("R6 word count", 32'(stbCount - base), 32'd4);
      chkEq("R6 word order", {byteLog[(base + 3) % 64], byteLog[(base + 2) % 64],
                              byteLog[(base + 1) % 64], byteLog[base % 64]},
            32'h12345678 + 32'(d));
      base = stbCount;
      access(0, 3'd3, 1, 2'd2, 32'hAABBCCDD, rd);
      chkEq("R6 addr single byte", 32'(stbCount - base), 32'd1);
      chkEq("R6 addr low byte", 32'(byteLog[base % 64]), 32'hDD);
      chkEq("R5 addr strobe kind", 32'(kindLog[base % 64]), 32'd1);
    end

    // R4 gated reads at width
    access(0, 3'd4, 0, 2'd1, 0, rd); chkEq("R4 gated half", rd, 32'h0000FFFF);
    access(0, 3'd4, 0, 2'd2, 0, rd); chkEq("R4 gated word", rd, 32'hFFFFFFFF);

    // R7 read assembly
    access(0, 3'd2, 1, 2'd0, 32'h24, rd);
    for (int d = 0; d < 3; d++) begin
      logic [7:0] b0;
      respDelay = d;
      base = stbCount;
      b0 = 8'h41 + 8'(base);
      access(0, 3'd4, 0, 2'd2, 0, rd);
      chkEq("R7 word read", rd, {b0 + 8'd3, b0 + 8'd2, b0 + 8'd1, b0});
      chkEq("R5 read direction", 32'(wrLog[base % 64]), 32'd0);
      base = stbCount;
      b0 = 8'h41 + 8'(base);
      access(0, 3'd4, 0, 2'd1, 0, rd);
      chkEq("R7 half read", rd, {16'd0, b0 + 8'd1, b0});
      base = stbCount;
      b0 = 8'h41 + 8'(base);
      access(0, 3'd3, 0, 2'd2, 0, rd);
      chkEq("R7 addr read", rd, {24'd0, b0});
    end
    respDelay = 0;

    // R8 / R9 timeout and clearing
    access(0, 3'd2, 1, 2'd0, 32'h04, rd);
    deaf = 1'b1;
    base = stbCount;
    access(0, 3'd4, 1, 2'd2, 32'hCAFEF00D, rd);
    chkEq("R8 remaining bytes skipped", 32'(stbCount - base), 32'd1);
    deaf = 1'b0;
    periphStatus = 8'hA6;
    access(0, 3'd1, 0, 2'd0, 0, rd); chkEq("R8 R9 flag in status", rd, 32'hA7);
    access(0, 3'd1, 1, 2'd0, 32'h00, rd);
    access(0, 3'd1, 0, 2'd0, 0, rd); chkEq("R9 write zero keeps flag", rd, 32'hA7);
    access(0, 3'd1, 1, 2'd0, 32'h01, rd);
    access(0, 3'd1, 0, 2'd0, 0, rd); chkEq("R9 write one clears", rd, 32'hA6);

    // R2 equal writes and forced bits
    access(0, 3'd2, 1, 2'd0, 32'hC4, rd); chkEq("R2 equal ctrl no load", 32'(sawCtrlLoad), 32'd0);
    access(0, 3'd2, 1, 2'd0, 32'h2A, rd); chkEq("R2 ctrl load pulse", 32'(sawCtrlLoad), 32'd1);
    chkEq("R2 ctrl forced bits", 32'(portCtrl), 32'hEA);
    access(0, 3'd0, 1, 2'd0, 32'h33, rd); chkEq("R2 data load pulse", 32'(sawDataLoad), 32'd1);
    access(0, 3'd0, 1, 2'd0, 32'h33, rd); chkEq("R2 equal data no load", 32'(sawDataLoad), 32'd0);
    access(0, 3'd0, 0, 2'd0, 0, rd); chkEq("R2 data readback", rd, 32'h33);

    // R10 extended window
    for (int a = 0; a < 8; a++) begin
      access(1, 3'(a), 0, 2'd0, 0, rd); chkEq("R10 ext read", rd, 32'hFF);
    end
    access(1, 3'd2, 1, 2'd0, 32'h04, rd); chkEq("R10 ext write no load", 32'(sawCtrlLoad), 32'd0);
    access(0, 3'd2, 0, 2'd0, 0, rd); chkEq("R10 ctrl untouched", rd, 32'hEA);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule